// File: doc/BRIEF.md
# Boundary-Scan Register Chain

This block is a chain of boundary-scan cells that sits between a device's pins and its core logic. Every cell can capture the value on its normal input, pass it down a serial path toward the test data output, and hold a stimulus value in a separate update stage. Cells on the output side can drive their pin from that update stage instead of from the core. Input-side cells only observe: the core always sees the live pin value.

A TAP controller outside this block supplies the capture, shift and update strobes, the test clock, and a two-bit mode select. In normal mode the chain is not selected, so the strobes do nothing and data passes straight through. In sample/preload mode the pins keep working normally while the chain snapshots live traffic and loads a stimulus in advance. In external-test mode the output pins are driven from the update stage. Because scan and update storage are separate, a new stimulus can be shifted in and the previous response shifted out while the driven pins stay steady.

Top module: `bscan_chain`

## Requirements
- R1: After reset, every scan flop and every update latch holds 0. `serial_o` therefore reads 0, and in external-test mode `pin_out_o` reads 0 until the first update.
- R2: `mode_i` encodes 2'b00 normal, 2'b01 sample/preload, 2'b10 external test and 2'b11 normal. In any mode except external test, `pin_out_o` equals `core_out_i` combinationally.
- R3: In external-test mode, `pin_out_o[k]` equals the update latch of chain cell `N_IN+k`. Changes on `core_out_i` do not affect the pins.
- R4: In sample/preload or external-test mode, a rising clock edge with `capture_i` high loads each scan flop from its normal input. Cells 0..N_IN-1 take `pin_in_i[0..N_IN-1]` and cells N_IN..N_IN+N_OUT-1 take `core_out_i`.
- R5: On each rising edge with `shift_i` high and the chain selected, cell i takes the value of cell i+1 and the last cell takes `serial_i`. `serial_o` is cell 0. After exactly N_IN+N_OUT shifts, every captured bit has appeared on `serial_o` in index order, and bit k of the shifted-in word is held by cell k.
- R6: When `capture_i` and `shift_i` are both high on the same edge, capture takes priority and the shift is discarded.
- R7: On a falling clock edge with `update_i` high and the chain selected, every update latch loads from its scan flop. In external-test mode the new pin value is visible after that edge.
- R8: Update latches change only on a falling edge with `update_i` high. During shift and capture, the driven pins stay constant.
- R9: In normal mode (2'b00 or 2'b11), the capture, shift and update strobes are ignored. Scan flops, update latches and `serial_o` keep their values.
- R10: `core_in_o` equals `pin_in_i` in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock; capture and shift act on the rising edge, update on the falling edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Mode select: 00 normal, 01 sample/preload, 10 external test, 11 normal |
| capture_i | input | 1 | Capture strobe |
| shift_i | input | 1 | Shift strobe |
| update_i | input | 1 | Update strobe |
| serial_i | input | 1 | Serial data into the last cell |
| pin_in_i | input | N_IN | Values arriving on input pins |
| core_out_i | input | N_OUT | Values the core wants on output pins |
| serial_o | output | 1 | Serial data out of cell 0 |
| core_in_o | output | N_IN | Input pin values delivered to the core |
| pin_out_o | output | N_OUT | Values driven onto output pins |

## Verification
Two functions can land in the same clock cycle: capture and shift, when a controller asserts both strobes together, and shifting while the output pins are being driven from the update stage. The bench raises capture and shift on one edge and expects the captured word to come out of `serial_o` in full. It also shifts a complete word in external-test mode and checks on every step that `pin_out_o` still shows the previously updated stimulus. A scoreboard queue holds the expected serial bit for every edge, and a monitor compares each bit after that edge.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef enum logic [1:0] {
    BS_NORMAL = 2'b00,
    BS_SAMPLE = 2'b01,
    BS_EXTEST = 2'b10,
    BS_SPARE  = 2'b11
  } bs_mode_e;
endpackage

// File: rtl/bscan_mode_dec.sv
module bscan_mode_dec
  import bscan_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       capture_i,
  input  logic       shift_i,
  input  logic       update_i,
  output logic       capture_o,
  output logic       shift_o,
  output logic       update_o,
  output logic       drive_o,
  output logic       normal_o
);
  logic sel;
  logic drv;

  always_comb begin
    sel = 1'b0;
    drv = 1'b0;
    case (bs_mode_e'(mode_i))
      BS_SAMPLE: sel = 1'b1;
      BS_EXTEST: begin
        sel = 1'b1;
        drv = 1'b1;
      end
      default: ;
    endcase
  end

  assign capture_o = capture_i & sel;
  assign shift_o   = shift_i & sel;
  assign update_o  = update_i & sel;
  assign drive_o   = drv;
  assign normal_o  = ~sel;
endmodule

// File: rtl/bscan_cell.sv
module bscan_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ni_i,
  input  logic si_i,
  input  logic capture_i,
  input  logic shift_i,
  input  logic update_i,
  input  logic drive_i,
  output logic no_o,
  output logic so_o
);
  logic scan_q;
  logic upd_q;

  // capture has priority over shift
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        scan_q <= 1'b0;
    else if (capture_i) scan_q <= ni_i;
    else if (shift_i)   scan_q <= si_i;
  end

  // falling-edge update keeps pins quiet while shifting
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       upd_q <= 1'b0;
    else if (update_i) upd_q <= scan_q;
  end

  assign no_o = drive_i ? upd_q : ni_i;
  assign so_o = scan_q;

  AST_CAPTURE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> scan_q == $past(ni_i)); // R4
  AST_CAPTURE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_i && shift_i) |=> scan_q == $past(ni_i)); // R6
  AST_SHIFT_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !capture_i) |=> scan_q == $past(si_i)); // R5
  AST_UPDATE_LOAD: assert property (@(negedge clk_i) disable iff (!rst_ni)
    update_i |=> upd_q == $past(scan_q)); // R7
  AST_UPDATE_HOLD: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !update_i |=> $stable(upd_q)); // R8
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             capture_i,
  input  logic             shift_i,
  input  logic             update_i,
  input  logic             serial_i,
  input  logic [N_IN-1:0]  pin_in_i,
  input  logic [N_OUT-1:0] core_out_i,
  output logic             serial_o,
  output logic [N_IN-1:0]  core_in_o,
  output logic [N_OUT-1:0] pin_out_o
);
  localparam int LEN = N_IN + N_OUT;

  logic           cap_en, sh_en, upd_en, drive, normal;
  logic [LEN-1:0] cell_ni, cell_no, cell_drv;
  logic [LEN:0]   link;

  bscan_mode_dec u_dec (
    .mode_i    (mode_i),
    .capture_i (capture_i),
    .shift_i   (shift_i),
    .update_i  (update_i),
    .capture_o (cap_en),
    .shift_o   (sh_en),
    .update_o  (upd_en),
    .drive_o   (drive),
    .normal_o  (normal)
  );

  assign cell_ni   = {core_out_i, pin_in_i};
  assign link[LEN] = serial_i;

  for (genvar g = 0; g < LEN; g++) begin : g_cell
    // input-side cells observe only
    if (g >= N_IN) begin : g_out
      assign cell_drv[g] = drive;
    end else begin : g_in
      assign cell_drv[g] = 1'b0;
    end

    bscan_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ni_i      (cell_ni[g]),
      .si_i      (link[g+1]),
      .capture_i (cap_en),
      .shift_i   (sh_en),
      .update_i  (upd_en),
      .drive_i   (cell_drv[g]),
      .no_o      (cell_no[g]),
      .so_o      (link[g])
    );
  end

  assign serial_o  = link[0];
  assign core_in_o = cell_no[N_IN-1:0];
  assign pin_out_o = cell_no[LEN-1:N_IN];

  AST_CORE_SEES_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_in_o == pin_in_i); // R10
  AST_NORMAL_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'b10) |-> pin_out_o == core_out_i); // R2
  AST_NORMAL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    normal |=> $stable(serial_o)); // R9
endmodule

// File: tb/bscan_chain_tb_top.sv
`timescale 1ns/1ps
module bscan_chain_tb_top;
  localparam int N_IN  = 4;
  localparam int N_OUT = 4;
  localparam int LEN   = N_IN + N_OUT;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [1:0]       mode_i = 2'b00;
  logic             capture_i = 1'b0, shift_i = 1'b0, update_i = 1'b0, serial_i = 1'b0;
  logic [N_IN-1:0]  pin_in_i = '0;
  logic [N_OUT-1:0] core_out_i = 4'h7;
  logic             serial_o;
  logic [N_IN-1:0]  core_in_o;
  logic [N_OUT-1:0] pin_out_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { string tag; logic val; } exp_t;
  exp_t exp_q[$];

  always #10 clk_i = ~clk_i;

  bscan_chain #(.N_IN(N_IN), .N_OUT(N_OUT)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
    .capture_i(capture_i), .shift_i(shift_i), .update_i(update_i),
    .serial_i(serial_i), .pin_in_i(pin_in_i), .core_out_i(core_out_i),
    .serial_o(serial_o), .core_in_o(core_in_o), .pin_out_o(pin_out_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // monitor: one expected serial bit per edge
  initial forever begin
    @(posedge clk_i);
    #3;
    if (exp_q.size() > 0) begin
      exp_t it;
      it = exp_q.pop_front();
      check(it.tag, 32'(serial_o), 32'(it.val));
    end
  end

  task automatic step(input logic cap, input logic sh, input logic upd, input logic si);
    capture_i = cap; shift_i = sh; update_i = upd; serial_i = si;
    @(posedge clk_i);
    #5;
  endtask

  // kind 0: capture then shift, 1: capture+shift together, 2: shift only
  task automatic scan(input int kind, input logic [LEN-1:0] cur, input logic [LEN-1:0] tdi,
                      input logic [N_OUT-1:0] pin_exp, input string tag);
    if (kind == 2) check({tag, " serial first"}, 32'(serial_o), 32'(cur[0]));
    else begin
      exp_q.push_back('{tag, cur[0]});
      step(1'b1, kind == 1, 1'b0, 1'b0);
    end
    for (int j = 0; j < LEN; j++) begin
      exp_q.push_back('{tag, (j < LEN-1) ? cur[j+1] : tdi[0]});
      step(1'b0, 1'b1, 1'b0, tdi[j]);
      check({tag, " pins steady"}, 32'(pin_out_o), 32'(pin_exp)); // R8
    end
    step(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    done = 1'b1;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #5 rst_ni = 1'b1;
    step(0, 0, 0, 0);
    check("R1 serial after reset", 32'(serial_o), 0);
    check("R1 normal pins", 32'(pin_out_o), 32'h7);
    mode_i = 2'b10; #1;
    check("R1 update latches zero", 32'(pin_out_o), 0);

    // sample/preload
    mode_i = 2'b01; pin_in_i = 4'hA; core_out_i = 4'h3; #1;
    check("R2 sample passes core", 32'(pin_out_o), 32'h3);
    scan(0, 8'h3A, 8'hC5, 4'h3, "R4 R5 sample scan");
    step(0, 0, 1, 0);
    check("R2 sample after update", 32'(pin_out_o), 32'h3);
    mode_i = 2'b10; #1;
    check("R7 preload drives pins", 32'(pin_out_o), 32'hC);
    check("R10 core sees pin", 32'(core_in_o), 32'hA);

    // external test
    core_out_i = 4'h5; pin_in_i = 4'h6; #1;
    check("R3 core ignored", 32'(pin_out_o), 32'hC);
    check("R10 core sees pin extest", 32'(core_in_o), 32'h6);
    scan(0, 8'h56, 8'h9B, 4'hC, "R4 R8 extest scan");
    check("R8 before update", 32'(pin_out_o), 32'hC);
    step(0, 0, 1, 0);
    check("R7 update drives pins", 32'(pin_out_o), 32'h9);

    // capture and shift in the same edge
    pin_in_i = 4'h1; core_out_i = 4'h2;
    scan(1, 8'h21, 8'h4E, 4'h9, "R6 capture wins");

    // normal mode ignores strobes
    mode_i = 2'b00; pin_in_i = 4'hF; core_out_i = 4'hF;
    step(1, 0, 0, 0);
    step(0, 1, 0, 1);
    step(0, 0, 1, 0);
    step(0, 0, 0, 0);
    check("R2 normal passes core", 32'(pin_out_o), 32'hF);
    mode_i = 2'b10; #1;
    check("R9 update latch kept", 32'(pin_out_o), 32'h9);
    scan(2, 8'h4E, 8'h00, 4'h9, "R9 R5 scan flops kept");

    mode_i = 2'b11; core_out_i = 4'hE; #1;
    check("R2 spare code is normal", 32'(pin_out_o), 32'hE);
    check("R10 core sees pin spare", 32'(core_in_o), 32'hF);
    step(0, 0, 0, 0);
    done = 1'b1;
  end

  initial begin
    wait (done);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule